// File: doc/BRIEF.md
# Privilege-Mode Virtual Address Segment Checker

This block sorts each 32-bit virtual address presented by a load/store or fetch pipeline into one of three outcomes, based on the current privilege mode and the two exception status bits.

- **Direct.** The address lies in a kernel window that bypasses mapping. The block returns the physical address and a cacheability attribute at once.
- **Translate.** The address is legal but must be looked up in the translation buffer.
- **Fault.** The address is illegal in the current mode. The fault is tagged as a load or a store, so the pipeline can raise the matching exception.

The decision is combinational. It is captured in an output register, so results appear one clock after the request. The translation buffer itself and any cache behaviour lie outside this block. A separate warning output reports requests that arrive with the reserved mode code. That code is still handled as kernel mode.

Top module: `vaddr_seg_classifier`

## Requirements
- R1: When either exception-status input (`exc_lvl` or `err_lvl`) is 1, the request is classified as kernel mode, whatever `priv_mode` holds.
- R2: `priv_mode` encoding is 0 = kernel, 1 = supervisor, 2 = user. Code 3 is reserved and is classified exactly as kernel.
- R3: In kernel mode, an address in 0x80000000..0x9FFFFFFF gives `direct_done`=1, `uncached`=0 and `paddr` = address − 0x80000000.
- R4: In kernel mode, an address in 0xA0000000..0xBFFFFFFF gives `direct_done`=1, `uncached`=1 and `paddr` = address − 0xA0000000. `uncached` is 0 whenever `direct_done` is 0.
- R5: In supervisor mode, an address whose bits [31:29] are neither 3'b000 nor 3'b110 gives `addr_err`=1.
- R6: In user mode, an address with bit 31 set gives `addr_err`=1.
- R7: Every other address gives `tlb_req`=1. This covers kernel addresses outside 0x80000000..0xBFFFFFFF, supervisor addresses with bits [31:29] equal to 000 or 110, and user addresses with bit 31 clear.
- R8: For each valid request, exactly one of `direct_done`, `tlb_req` and `addr_err` is 1. With no request, all three are 0. `paddr` is 0 unless `direct_done` is 1.
- R9: `err_is_store` equals `is_store` (1 = store, 0 = load) when `addr_err` is 1, and is 0 otherwise.
- R10: `mode_rsvd_warn` is 1 for a valid request whose `priv_mode` is 3, whatever the exception bits hold, and is 0 otherwise.
- R11: Results appear on the outputs one clock after the request is sampled, qualified by `out_valid`. After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| priv_mode | input | 2 | Privilege mode field (0 kernel, 1 supervisor, 2 user, 3 reserved) |
| exc_lvl | input | 1 | Exception-level status bit |
| err_lvl | input | 1 | Error-level status bit |
| vaddr | input | VA_W | Virtual address |
| is_store | input | 1 | 1 = store access, 0 = load access |
| out_valid | output | 1 | Registered result is valid |
| paddr | output | VA_W | Physical address for direct windows |
| uncached | output | 1 | Direct window is uncached |
| direct_done | output | 1 | Address translated directly |
| tlb_req | output | 1 | Address must be mapped by the translation buffer |
| addr_err | output | 1 | Address error for this mode |
| err_is_store | output | 1 | Address error was caused by a store |
| mode_rsvd_warn | output | 1 | Request carried the reserved mode code |

## Verification
The bench builds the block with its defaults: a 32-bit address and the registered output stage. The outcome depends only on the top three address bits, the mode field, the two exception bits and the access direction. A full sweep over all 256 combinations of these inputs is therefore within reach. Each combination is repeated with three lower-bit patterns: all zeros, all ones and a mixed value. This exposes both window edges and the subtraction that forms the physical address. Idle cycles between requests confirm that the strobes stay quiet.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
   typedef enum logic [1:0] {
      MODE_KERN = 2'd0,
      MODE_SUPV = 2'd1,
      MODE_USER = 2'd2,
      MODE_RSVD = 2'd3
   } priv_mode_e;

   typedef enum logic [1:0] {
      CLS_NONE   = 2'd0,
      CLS_DIRECT = 2'd1,
      CLS_TLB    = 2'd2,
      CLS_FAULT  = 2'd3
   } seg_class_e;

   // Number of address bits that select a segment region
   localparam int REGION_BITS = 3;
endpackage

// File: rtl/vseg_mode_resolve.sv
module vseg_mode_resolve
   import vseg_pkg::*;
(
   input  logic [1:0]  mode_field,
   input  logic        exc_lvl,
   input  logic        err_lvl,
   output priv_mode_e  eff_mode,
   output logic        rsvd_code
);
   always_comb begin
      rsvd_code = (mode_field == 2'd3);
      if (exc_lvl || err_lvl) begin
         eff_mode = MODE_KERN;
      end else begin
         unique case (mode_field)
            2'd1:    eff_mode = MODE_SUPV;
            2'd2:    eff_mode = MODE_USER;
            default: eff_mode = MODE_KERN;   // 0 and reserved 3
         endcase
      end
   end
endmodule

// File: rtl/vseg_region_decode.sv
module vseg_region_decode
   import vseg_pkg::*;
#(
   parameter int VA_W = 32
) (
   input  priv_mode_e        eff_mode,
   input  logic [VA_W-1:0]   vaddr,
   output seg_class_e        cls,
   output logic              unc,
   output logic [VA_W-1:0]   pa
);
   localparam int LOW_W = VA_W - REGION_BITS;

   logic [REGION_BITS-1:0] region;
   assign region = vaddr[VA_W-1 -: REGION_BITS];

   // Both direct windows start on a region boundary, so subtracting the
   // window base is the same as clearing the region bits.
   assign pa = {{REGION_BITS{1'b0}}, vaddr[LOW_W-1:0]};

   always_comb begin
      cls = CLS_TLB;
      unc = 1'b0;
      unique case (eff_mode)
         MODE_SUPV: begin
            if (region != 3'b000 && region != 3'b110)
               cls = CLS_FAULT;
         end
         MODE_USER: begin
            if (region[2])
               cls = CLS_FAULT;
         end
         default: begin
            if (region[2:1] == 2'b10) begin
               cls = CLS_DIRECT;
               unc = region[0];
            end
         end
      endcase
   end
endmodule

// File: rtl/vseg_out_stage.sv
module vseg_out_stage
   import vseg_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  seg_class_e        in_cls,
   input  logic              in_unc,
   input  logic [VA_W-1:0]   in_pa,
   input  logic              in_store,
   input  logic              in_rsvd,
   output logic              o_valid,
   output logic [VA_W-1:0]   o_pa,
   output logic              o_unc,
   output logic              o_direct,
   output logic              o_tlb,
   output logic              o_err,
   output logic              o_err_st,
   output logic              o_rsvd
);
   logic              n_direct, n_tlb, n_err, n_err_st, n_unc, n_rsvd;
   logic [VA_W-1:0]   n_pa;

   always_comb begin
      n_direct = in_valid && (in_cls == CLS_DIRECT);
      n_tlb    = in_valid && (in_cls == CLS_TLB);
      n_err    = in_valid && (in_cls == CLS_FAULT);
      n_err_st = n_err && in_store;
      n_unc    = n_direct && in_unc;
      n_rsvd   = in_valid && in_rsvd;
      n_pa     = n_direct ? in_pa : '0;
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_valid  <= 1'b0;
               o_pa     <= '0;
               o_unc    <= 1'b0;
               o_direct <= 1'b0;
               o_tlb    <= 1'b0;
               o_err    <= 1'b0;
               o_err_st <= 1'b0;
               o_rsvd   <= 1'b0;
            end else begin
               o_valid  <= in_valid;
               o_pa     <= n_pa;
               o_unc    <= n_unc;
               o_direct <= n_direct;
               o_tlb    <= n_tlb;
               o_err    <= n_err;
               o_err_st <= n_err_st;
               o_rsvd   <= n_rsvd;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign o_valid  = in_valid;
         assign o_pa     = n_pa;
         assign o_unc    = n_unc;
         assign o_direct = n_direct;
         assign o_tlb    = n_tlb;
         assign o_err    = n_err;
         assign o_err_st = n_err_st;
         assign o_rsvd   = n_rsvd;
      end
   endgenerate
endmodule

// File: rtl/vaddr_seg_classifier.sv
module vaddr_seg_classifier
   import vseg_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        priv_mode,
   input  logic              exc_lvl,
   input  logic              err_lvl,
   input  logic [VA_W-1:0]   vaddr,
   input  logic              is_store,
   output logic              out_valid,
   output logic [VA_W-1:0]   paddr,
   output logic              uncached,
   output logic              direct_done,
   output logic              tlb_req,
   output logic              addr_err,
   output logic              err_is_store,
   output logic              mode_rsvd_warn
);
   generate
      if (VA_W < 8) begin : g_bad_width
         $error("vaddr_seg_classifier: VA_W must be at least 8");
      end
   endgenerate

   priv_mode_e        eff_mode;
   logic              rsvd_code;
   seg_class_e        cls;
   logic              unc;
   logic [VA_W-1:0]   pa;

   vseg_mode_resolve i_mode (
      .mode_field (priv_mode),
      .exc_lvl    (exc_lvl),
      .err_lvl    (err_lvl),
      .eff_mode   (eff_mode),
      .rsvd_code  (rsvd_code)
   );

   vseg_region_decode #(.VA_W(VA_W)) i_region (
      .eff_mode (eff_mode),
      .vaddr    (vaddr),
      .cls      (cls),
      .unc      (unc),
      .pa       (pa)
   );

   vseg_out_stage #(.VA_W(VA_W), .OUT_REG(OUT_REG)) i_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (req_valid),
      .in_cls   (cls),
      .in_unc   (unc),
      .in_pa    (pa),
      .in_store (is_store),
      .in_rsvd  (rsvd_code),
      .o_valid  (out_valid),
      .o_pa     (paddr),
      .o_unc    (uncached),
      .o_direct (direct_done),
      .o_tlb    (tlb_req),
      .o_err    (addr_err),
      .o_err_st (err_is_store),
      .o_rsvd   (mode_rsvd_warn)
   );
endmodule

// File: rtl/vseg_checker.sv
module vseg_checker #(
   parameter int VA_W    = 32,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        priv_mode,
   input logic              exc_lvl,
   input logic              err_lvl,
   input logic [VA_W-1:0]   vaddr,
   input logic              is_store,
   input logic              out_valid,
   input logic [VA_W-1:0]   paddr,
   input logic              uncached,
   input logic              direct_done,
   input logic              tlb_req,
   input logic              addr_err,
   input logic              err_is_store,
   input logic              mode_rsvd_warn
);
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones({direct_done, tlb_req, addr_err}) == 1); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(direct_done || tlb_req || addr_err || mode_rsvd_warn)); // R8
   AST_ERR_DIR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      err_is_store |-> addr_err); // R9
   AST_UNC_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      !direct_done |-> !uncached); // R4

   generate
      if (OUT_REG) begin : g_seq
         AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> out_valid); // R11
         AST_EXC_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && (exc_lvl || err_lvl) && vaddr[VA_W-1 -: 2] == 2'b10)
            |=> direct_done); // R1
         AST_USER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && priv_mode == 2'd2 && !exc_lvl && !err_lvl && vaddr[VA_W-1])
            |=> addr_err); // R6
         AST_FAULT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && priv_mode == 2'd2 && !exc_lvl && !err_lvl && vaddr[VA_W-1] && is_store)
            |=> err_is_store); // R9
         AST_RSVD_WARN: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && priv_mode == 2'd3) |=> mode_rsvd_warn); // R10
         AST_DIRECT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && $past(req_valid) == $past(req_valid)) |=> (!direct_done ||
             paddr == {3'b000, $past(vaddr[VA_W-4:0])})); // R3
      end else begin : g_comb
         AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |-> out_valid); // R11
         AST_EXC_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && (exc_lvl || err_lvl) && vaddr[VA_W-1 -: 2] == 2'b10)
            |-> direct_done); // R1
         AST_USER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && priv_mode == 2'd2 && !exc_lvl && !err_lvl && vaddr[VA_W-1])
            |-> addr_err); // R6
         AST_FAULT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && priv_mode == 2'd2 && !exc_lvl && !err_lvl && vaddr[VA_W-1] && is_store)
            |-> err_is_store); // R9
         AST_RSVD_WARN: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && priv_mode == 2'd3) |-> mode_rsvd_warn); // R10
         AST_DIRECT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
            direct_done |-> paddr == {3'b000, vaddr[VA_W-4:0]}); // R3
      end
   endgenerate
endmodule

bind vaddr_seg_classifier vseg_checker #(.VA_W(VA_W), .OUT_REG(OUT_REG)) i_chk (.*);

// File: tb/test_vaddr_seg_classifier.sv
module test_vaddr_seg_classifier;
   localparam int CLK_PERIOD = 10;
   localparam int VA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [1:0]        priv_mode = 2'd0;
   logic              exc_lvl = 1'b0;
   logic              err_lvl = 1'b0;
   logic [VA_W-1:0]   vaddr = '0;
   logic              is_store = 1'b0;
   logic              out_valid;
   logic [VA_W-1:0]   paddr;
   logic              uncached, direct_done, tlb_req, addr_err, err_is_store, mode_rsvd_warn;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vaddr_seg_classifier #(.VA_W(VA_W), .OUT_REG(1'b1)) i_vaddr_seg_classifier (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .priv_mode      (priv_mode),
      .exc_lvl        (exc_lvl),
      .err_lvl        (err_lvl),
      .vaddr          (vaddr),
      .is_store       (is_store),
      .out_valid      (out_valid),
      .paddr          (paddr),
      .uncached       (uncached),
      .direct_done    (direct_done),
      .tlb_req        (tlb_req),
      .addr_err       (addr_err),
      .err_is_store   (err_is_store),
      .mode_rsvd_warn (mode_rsvd_warn)
   );

   // Packed observation: {valid, direct, tlb, err, err_st, unc, warn, paddr}
   function automatic logic [VA_W+6:0] observe();
      return {out_valid, direct_done, tlb_req, addr_err, err_is_store,
              uncached, mode_rsvd_warn, paddr};
   endfunction

   task automatic check(input string tag, input logic [VA_W+6:0] exp);
      logic [VA_W+6:0] got;
      got = observe();
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h (va=%h mode=%0d exc=%0b err=%0b st=%0b)",
                  tag, got, exp, vaddr, priv_mode, exc_lvl, err_lvl, is_store);
      end
   endtask

   // Expected outcome computed from the requirement text
   task automatic apply(input logic [1:0] m, input logic e, input logic x,
                        input logic [VA_W-1:0] va, input logic st);
      logic [2:0] rg;
      logic kern, dir, tlb, err, unc, warn;
      logic [VA_W-1:0] pa;
      string tag;
      rg   = va[VA_W-1 -: 3];
      kern = e || x || m == 2'd0 || m == 2'd3;            // R1, R2
      dir = 0; tlb = 0; err = 0; unc = 0; pa = '0;
      if (kern) begin
         if (va >= 32'h8000_0000 && va <= 32'h9FFF_FFFF) begin
            dir = 1; pa = va - 32'h8000_0000;               // R3
         end else if (va >= 32'hA000_0000 && va <= 32'hBFFF_FFFF) begin
            dir = 1; unc = 1; pa = va - 32'hA000_0000;      // R4
         end else tlb = 1;                                  // R7
      end else if (m == 2'd1) begin
         if (rg != 3'b000 && rg != 3'b110) err = 1; else tlb = 1;   // R5
      end else begin
         if (va[31]) err = 1; else tlb = 1;                 // R6
      end
      warn = (m == 2'd3);                                   // R10
      if (m == 2'd3 && !e && !x) tag = "R2";
      else if (e || x) tag = "R1";
      else if (dir && !unc) tag = "R3";
      else if (dir) tag = "R4";
      else if (err && m == 2'd1) tag = "R5";
      else if (err) tag = "R6";
      else tag = "R7";
      @(negedge clk);
      req_valid = 1'b1; priv_mode = m; exc_lvl = e; err_lvl = x;
      vaddr = va; is_store = st;
      @(posedge clk);
      #(CLK_PERIOD/4);
      // one outcome (R8), store flag (R9), warning (R10), one-cycle latency (R11)
      check(tag, {1'b1, dir, tlb, err, err && st, unc, warn, pa});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [VA_W-4:0] lows [3];
      lows[0] = '0;
      lows[1] = '1;
      lows[2] = 29'h0ABC_1234;
      repeat (3) @(posedge clk);
      #1;
      check("R11 reset", '0);
      rst_n = 1'b1;
      @(posedge clk);
      #(CLK_PERIOD/4);
      check("R11 idle", '0);
      for (int m = 0; m < 4; m++)
         for (int ex = 0; ex < 4; ex++)
            for (int rg = 0; rg < 8; rg++)
               for (int lo = 0; lo < 3; lo++)
                  for (int st = 0; st < 2; st++)
                     apply(m[1:0], ex[0], ex[1], {rg[2:0], lows[lo]}, st[0]);
      // Idle after a request: no strobes, paddr zero (R8)
      @(negedge clk);
      req_valid = 1'b0; priv_mode = 2'd3; vaddr = 32'h8000_0040; is_store = 1'b1;
      @(posedge clk);
      #(CLK_PERIOD/4);
      check("R8 idle", '0);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule